// File: doc/BRIEF.md
# Task-Tagged Memory Protection Unit

This block checks every data memory access against a small table of protection regions. Each region carries the identifier of the task that owns it. The check runs in the same cycle as the access and uses only the regions tagged with the task identifier that comes with the access. A task switch therefore needs no reprogramming of the table, and the check adds no wait state to single-cycle execution or to task dispatch.

The lookup has two stages. First, every entry compares the word address against its inclusive base/limit range in parallel. Then a selection stage keeps only the valid entries of the current task that grant the needed read or write permission. An access with no granting entry raises `fault_o`, so the core can halt before the bad access takes effect. The first fault, and its address, is also held in a sticky status register until software clears it.

The table is written through a configuration port that takes an entry index, a field select and a data word, for example from an initialisation task. A build-time parameter can fix the whole table as constants instead. The write port then has no effect.

Top module: `task_mpu`

## Requirements
- R1: After reset every table entry is invalid. Every valid access then faults, and the sticky status reads clear.
- R2: An entry grants an access when all of these hold: the entry is valid, its task id equals `acc_tid_i`, base <= address <= limit (compared on the word address, bits [ADDR_W-1:2]), and it has read permission for a read or write permission for a write. A write is signalled by `acc_wr_i`=1.
- R3: An entry owned by another task never grants an access, even when its range and permissions match.
- R4: `permit_o` and `fault_o` are combinational in the access inputs and are valid in the same cycle as the access.
- R5: While `acc_valid_i` is low, both `fault_o` and `permit_o` are low. While it is high, exactly one of them is high.
- R6: When several entries cover the address, the access is permitted if any granting entry of the current task exists. A non-granting overlap does not block it.
- R7: Configuration field encoding: 0 is base, 1 is limit, 2 is flags. Flags bit 0 is valid, bit 1 is read, bit 2 is write, and bits [8 +: TASK_W] are the task id. A write takes effect on the next clock edge and is visible to checks from the next cycle. It is not visible in the cycle it is issued.
- R8: A faulting access sets `sts_fault_o` at the next edge and records its address in `sts_addr_o`. Later faults do not overwrite the record until `sts_clr_i` is pulsed. A clear without a fault in the same cycle drops `sts_fault_o`. A fault in the same cycle as a clear is recorded.
- R9: With `STATIC_CFG`=1 the table comes from parameters, and configuration writes change no access result.
- R10: Base and limit are inclusive. The words just below the base and just above the limit fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe |
| acc_tid_i | input | TASK_W | Running task identifier |
| acc_addr_i | input | ADDR_W | Access byte address |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| permit_o | output | 1 | Access allowed |
| fault_o | output | 1 | Access violates protection |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_idx_i | input | IDX_W | Entry index |
| cfg_field_i | input | 2 | Field select (0 base, 1 limit, 2 flags) |
| cfg_data_i | input | ADDR_W | Field data |
| sts_clr_i | input | 1 | Clear sticky status |
| sts_fault_o | output | 1 | Sticky fault flag |
| sts_addr_o | output | ADDR_W | Address of the recorded fault |

## Verification
The assertions check on every cycle that the outputs stay quiet without a strobe and that exactly one of permit and fault is high with one. They also check that an empty table always faults, that nothing is permitted without a valid entry, and that the sticky status captures, holds and clears as specified. Range boundaries, task tagging, overlapping regions, the one-cycle delay before a configuration write takes effect and the immunity of the constant table can only be shown by the bench's scenarios, which compare outputs against hand-computed expectations.

// File: rtl/task_mpu_pkg.sv
package task_mpu_pkg;
  localparam int unsigned WORD_LSB = 2;

  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_LIMIT = 2'd1,
    FLD_FLAGS = 2'd2
  } cfg_field_e;

  localparam int unsigned FLG_VLD = 0;
  localparam int unsigned FLG_RD  = 1;
  localparam int unsigned FLG_WR  = 2;
  localparam int unsigned FLG_TID = 8;
endpackage

// File: rtl/mpu_region_table.sv
module mpu_region_table
  import task_mpu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned TASK_W      = 4,
  parameter bit          STATIC_CFG  = 1'b0,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] FIXED_BASE  = '0,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] FIXED_LIMIT = '0,
  parameter logic [NUM_REGIONS-1:0][TASK_W-1:0] FIXED_TID   = '0,
  parameter logic [NUM_REGIONS-1:0]             FIXED_VLD   = '0,
  parameter logic [NUM_REGIONS-1:0]             FIXED_RD    = '0,
  parameter logic [NUM_REGIONS-1:0]             FIXED_WR    = '0,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int unsigned WA_W  = ADDR_W - WORD_LSB
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 cfg_we_i,
  input  logic [IDX_W-1:0]                     cfg_idx_i,
  input  logic [1:0]                           cfg_field_i,
  input  logic [ADDR_W-1:0]                    cfg_data_i,
  output logic [NUM_REGIONS-1:0][WA_W-1:0]     base_o,
  output logic [NUM_REGIONS-1:0][WA_W-1:0]     limit_o,
  output logic [NUM_REGIONS-1:0][TASK_W-1:0]   tid_o,
  output logic [NUM_REGIONS-1:0]               vld_o,
  output logic [NUM_REGIONS-1:0]               rd_o,
  output logic [NUM_REGIONS-1:0]               wr_o
);
  if (STATIC_CFG) begin : g_static
    logic unused_cfg;
    assign unused_cfg = ^{clk_i, rst_ni, cfg_we_i, cfg_idx_i, cfg_field_i, cfg_data_i};
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_ent
      assign base_o[g]  = FIXED_BASE[g][ADDR_W-1:WORD_LSB];
      assign limit_o[g] = FIXED_LIMIT[g][ADDR_W-1:WORD_LSB];
    end
    assign tid_o = FIXED_TID;
    assign vld_o = FIXED_VLD;
    assign rd_o  = FIXED_RD;
    assign wr_o  = FIXED_WR;
  end else begin : g_dyn
    cfg_field_e fld;
    assign fld = cfg_field_e'(cfg_field_i);
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_ent
      logic sel;
      assign sel = cfg_we_i && (cfg_idx_i == IDX_W'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_o[g]  <= '0;
          limit_o[g] <= '0;
          tid_o[g]   <= '0;
          vld_o[g]   <= 1'b0;
          rd_o[g]    <= 1'b0;
          wr_o[g]    <= 1'b0;
        end else if (sel) begin
          unique case (fld)
            FLD_BASE:  base_o[g]  <= cfg_data_i[ADDR_W-1:WORD_LSB];
            FLD_LIMIT: limit_o[g] <= cfg_data_i[ADDR_W-1:WORD_LSB];
            FLD_FLAGS: begin
              vld_o[g] <= cfg_data_i[FLG_VLD];
              rd_o[g]  <= cfg_data_i[FLG_RD];
              wr_o[g]  <= cfg_data_i[FLG_WR];
              tid_o[g] <= cfg_data_i[FLG_TID +: TASK_W];
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mpu_range_match.sv
module mpu_range_match #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned WA_W        = 30
) (
  input  logic [WA_W-1:0]                  word_addr_i,
  input  logic [NUM_REGIONS-1:0][WA_W-1:0] base_i,
  input  logic [NUM_REGIONS-1:0][WA_W-1:0] limit_i,
  output logic [NUM_REGIONS-1:0]           in_range_o
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    assign in_range_o[g] = (word_addr_i >= base_i[g]) && (word_addr_i <= limit_i[g]);
  end
endmodule

// File: rtl/mpu_grant_select.sv
module mpu_grant_select #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned TASK_W      = 4
) (
  input  logic [NUM_REGIONS-1:0]             in_range_i,
  input  logic [NUM_REGIONS-1:0][TASK_W-1:0] tid_i,
  input  logic [NUM_REGIONS-1:0]             vld_i,
  input  logic [NUM_REGIONS-1:0]             rd_i,
  input  logic [NUM_REGIONS-1:0]             wr_i,
  input  logic [TASK_W-1:0]                  acc_tid_i,
  input  logic                               acc_wr_i,
  output logic                               grant_o
);
  logic [NUM_REGIONS-1:0] hit;
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_sel
    assign hit[g] = vld_i[g] && in_range_i[g] && (tid_i[g] == acc_tid_i)
                    && (acc_wr_i ? wr_i[g] : rd_i[g]);
  end
  assign grant_o = |hit;
endmodule

// File: rtl/mpu_fault_status.sv
module mpu_fault_status #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  output logic              sts_fault_o,
  output logic [ADDR_W-1:0] sts_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_fault_o <= 1'b0;
      sts_addr_o  <= '0;
    end else if (fault_i) begin
      // first fault wins; a clear in the same cycle re-arms capture
      if (!sts_fault_o || clr_i) begin
        sts_fault_o <= 1'b1;
        sts_addr_o  <= addr_i;
      end
    end else if (clr_i) begin
      sts_fault_o <= 1'b0;
    end
  end
endmodule

// File: rtl/task_mpu.sv
module task_mpu
  import task_mpu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned TASK_W      = 4,
  parameter bit          STATIC_CFG  = 1'b0,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] FIXED_BASE  = '0,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] FIXED_LIMIT = '0,
  parameter logic [NUM_REGIONS-1:0][TASK_W-1:0] FIXED_TID   = '0,
  parameter logic [NUM_REGIONS-1:0]             FIXED_VLD   = '0,
  parameter logic [NUM_REGIONS-1:0]             FIXED_RD    = '0,
  parameter logic [NUM_REGIONS-1:0]             FIXED_WR    = '0,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int unsigned WA_W  = ADDR_W - WORD_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [TASK_W-1:0] acc_tid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_wr_i,
  output logic              permit_o,
  output logic              fault_o,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [1:0]        cfg_field_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic              sts_clr_i,
  output logic              sts_fault_o,
  output logic [ADDR_W-1:0] sts_addr_o
);
  logic [NUM_REGIONS-1:0][WA_W-1:0]   ent_base, ent_limit;
  logic [NUM_REGIONS-1:0][TASK_W-1:0] ent_tid;
  logic [NUM_REGIONS-1:0]             ent_vld, ent_rd, ent_wr, in_range;
  logic                               grant;

  mpu_region_table #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .TASK_W(TASK_W), .STATIC_CFG(STATIC_CFG),
    .FIXED_BASE(FIXED_BASE), .FIXED_LIMIT(FIXED_LIMIT), .FIXED_TID(FIXED_TID),
    .FIXED_VLD(FIXED_VLD), .FIXED_RD(FIXED_RD), .FIXED_WR(FIXED_WR)
  ) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
    .cfg_field_i(cfg_field_i), .cfg_data_i(cfg_data_i),
    .base_o(ent_base), .limit_o(ent_limit), .tid_o(ent_tid),
    .vld_o(ent_vld), .rd_o(ent_rd), .wr_o(ent_wr)
  );

  mpu_range_match #(.NUM_REGIONS(NUM_REGIONS), .WA_W(WA_W)) u_match (
    .word_addr_i(acc_addr_i[ADDR_W-1:WORD_LSB]), .base_i(ent_base),
    .limit_i(ent_limit), .in_range_o(in_range)
  );

  mpu_grant_select #(.NUM_REGIONS(NUM_REGIONS), .TASK_W(TASK_W)) u_select (
    .in_range_i(in_range), .tid_i(ent_tid), .vld_i(ent_vld), .rd_i(ent_rd),
    .wr_i(ent_wr), .acc_tid_i(acc_tid_i), .acc_wr_i(acc_wr_i), .grant_o(grant)
  );

  assign permit_o = acc_valid_i && grant;
  assign fault_o  = acc_valid_i && !grant;

  mpu_fault_status #(.ADDR_W(ADDR_W)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_o), .addr_i(acc_addr_i),
    .clr_i(sts_clr_i), .sts_fault_o(sts_fault_o), .sts_addr_o(sts_addr_o)
  );
endmodule

// File: rtl/task_mpu_chk.sv
module task_mpu_chk #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   acc_valid_i,
  input logic [ADDR_W-1:0]      acc_addr_i,
  input logic                   permit_o,
  input logic                   fault_o,
  input logic                   sts_clr_i,
  input logic                   sts_fault_o,
  input logic [ADDR_W-1:0]      sts_addr_o,
  input logic [NUM_REGIONS-1:0] ent_vld_i
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !fault_o && !permit_o); // R5
  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |-> $countones({fault_o, permit_o}) == 1); // R5
  AST_EMPTY_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && ent_vld_i == '0) |-> fault_o); // R1
  AST_GRANT_NEEDS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit_o |-> ent_vld_i != '0); // R2
  AST_STS_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && (!sts_fault_o || sts_clr_i)) |=> sts_fault_o && sts_addr_o == $past(acc_addr_i)); // R8
  AST_STS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_fault_o && !sts_clr_i) |=> sts_fault_o && $stable(sts_addr_o)); // R8
  AST_STS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr_i && !fault_o) |=> !sts_fault_o); // R8
endmodule

bind task_mpu task_mpu_chk #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
  .permit_o(permit_o), .fault_o(fault_o), .sts_clr_i(sts_clr_i),
  .sts_fault_o(sts_fault_o), .sts_addr_o(sts_addr_o), .ent_vld_i(ent_vld)
);

// File: tb/task_mpu_tb_top.sv
`timescale 1ns/1ps
module task_mpu_tb_top;
  localparam int unsigned N  = 8;
  localparam int unsigned AW = 32;
  localparam int unsigned TW = 4;
  localparam int unsigned IW = 3;

  localparam logic [N-1:0][AW-1:0] S_BASE  = {224'd0, 32'h0000_0100};
  localparam logic [N-1:0][AW-1:0] S_LIMIT = {224'd0, 32'h0000_01FC};
  localparam logic [N-1:0][TW-1:0] S_TID   = {28'd0, 4'd1};

  typedef struct packed {
    logic [TW-1:0] tid;
    logic [AW-1:0] addr;
    logic          wr;
    logic          flt;
  } vec_t;

  // table: E0 t1 0x1000-0x1FFC R; E1 t1 0x1800-0x18FC RW; E2 t2 0x1000-0x1FFC RW; E3 t3 invalid
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 32'h0000_1000, 1'b0, 1'b0},  // R10 base inclusive
    '{4'd1, 32'h0000_1FFC, 1'b0, 1'b0},  // R10 limit inclusive
    '{4'd1, 32'h0000_1FFE, 1'b0, 1'b0},  // R2 word granularity
    '{4'd1, 32'h0000_0FFC, 1'b0, 1'b1},  // R10 below base
    '{4'd1, 32'h0000_2000, 1'b0, 1'b1},  // R10 above limit
    '{4'd1, 32'h0000_1004, 1'b1, 1'b1},  // R2 no write perm
    '{4'd1, 32'h0000_1810, 1'b1, 1'b0},  // R6 overlap grants
    '{4'd1, 32'h0000_18FC, 1'b1, 1'b0},  // R6
    '{4'd1, 32'h0000_1900, 1'b1, 1'b1},  // R6 outside overlap
    '{4'd2, 32'h0000_1004, 1'b1, 1'b0},  // R3 own task
    '{4'd0, 32'h0000_1000, 1'b0, 1'b1},  // R3 foreign task
    '{4'd2, 32'h0000_2000, 1'b0, 1'b1},  // R3
    '{4'd3, 32'h0000_4000, 1'b0, 1'b1},  // R2 invalid entry
    '{4'd2, 32'h0000_1800, 1'b0, 1'b0}   // R4
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_wr = 1'b0, cfg_we = 1'b0, sts_clr = 1'b0;
  logic [TW-1:0] acc_tid = '0;
  logic [AW-1:0] acc_addr = '0, cfg_data = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [1:0]    cfg_field = '0;
  logic permit, fault, sts_fault, s_permit, s_fault, s_sts_fault;
  logic [AW-1:0] sts_addr, s_sts_addr;
  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  task_mpu #(.NUM_REGIONS(N), .ADDR_W(AW), .TASK_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_tid_i(acc_tid),
    .acc_addr_i(acc_addr), .acc_wr_i(acc_wr), .permit_o(permit), .fault_o(fault),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_field_i(cfg_field), .cfg_data_i(cfg_data),
    .sts_clr_i(sts_clr), .sts_fault_o(sts_fault), .sts_addr_o(sts_addr)
  );

  task_mpu #(.NUM_REGIONS(N), .ADDR_W(AW), .TASK_W(TW), .STATIC_CFG(1'b1),
    .FIXED_BASE(S_BASE), .FIXED_LIMIT(S_LIMIT), .FIXED_TID(S_TID),
    .FIXED_VLD(8'h01), .FIXED_RD(8'h01), .FIXED_WR(8'h01)
  ) dut_s_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_tid_i(acc_tid),
    .acc_addr_i(acc_addr), .acc_wr_i(acc_wr), .permit_o(s_permit), .fault_o(s_fault),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_field_i(cfg_field), .cfg_data_i(cfg_data),
    .sts_clr_i(sts_clr), .sts_fault_o(s_sts_fault), .sts_addr_o(s_sts_addr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] flags(input int tid, input bit v, input bit r, input bit w);
    logic [AW-1:0] d = '0;
    d[0] = v; d[1] = r; d[2] = w; d[8 +: TW] = TW'(tid);
    return d;
  endfunction

  task automatic cfg_wr(input int idx, input int fld, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_field = 2'(fld); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic region(input int idx, input logic [AW-1:0] b, input logic [AW-1:0] l,
                        input int tid, input bit v, input bit r, input bit w);
    cfg_wr(idx, 0, b);
    cfg_wr(idx, 1, l);
    cfg_wr(idx, 2, flags(tid, v, r, w));
  endtask

  task automatic access(input int tid, input logic [AW-1:0] a, input bit w);
    @(negedge clk);
    acc_valid = 1'b1; acc_tid = TW'(tid); acc_addr = a; acc_wr = w;
    #5;
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    access(1, 32'h1000, 0);
    check("R1 empty table faults", fault, 1'b1);
    check("R1 status clear", sts_fault, 1'b0);
    @(negedge clk); sts_clr = 1'b1; acc_valid = 1'b0;
    @(negedge clk); sts_clr = 1'b0;

    region(0, 32'h1000, 32'h1FFC, 1, 1, 1, 0);
    region(1, 32'h1800, 32'h18FC, 1, 1, 1, 1);
    region(2, 32'h1000, 32'h1FFC, 2, 1, 1, 1);
    region(3, 32'h4000, 32'h40FC, 3, 0, 1, 1);

    for (int i = 0; i < NV; i++) begin
      access(int'(VEC[i].tid), VEC[i].addr, VEC[i].wr);
      check($sformatf("R2/R4 vector %0d fault", i), fault, VEC[i].flt);
      check($sformatf("R5 vector %0d permit", i), permit, !VEC[i].flt);
    end

    // R5 no strobe
    @(negedge clk); acc_valid = 1'b0; acc_addr = 32'h9000; #5;
    check("R5 idle fault", fault, 1'b0);
    check("R5 idle permit", permit, 1'b0);

    // R7 write not visible same cycle, visible next
    @(negedge clk);
    sts_clr = 1'b1;
    acc_valid = 1'b1; acc_tid = 4'd3; acc_addr = 32'h4000; acc_wr = 1'b0;
    cfg_we = 1'b1; cfg_idx = 3'd3; cfg_field = 2'd2; cfg_data = flags(3, 1, 1, 1);
    #5;
    check("R7 same cycle still faults", fault, 1'b1);
    @(negedge clk); cfg_we = 1'b0; sts_clr = 1'b0; #5;
    check("R7 next cycle permits", permit, 1'b1);

    // R8 sticky status
    @(negedge clk); sts_clr = 1'b1; acc_valid = 1'b0;
    @(negedge clk); sts_clr = 1'b0;
    #5; check("R8 cleared", sts_fault, 1'b0);
    access(1, 32'h2000, 0);
    access(1, 32'h3000, 0);
    acc_valid = 1'b0;
    check("R8 set", sts_fault, 1'b1);
    check("R8 first address kept", sts_addr, 32'h2000);
    @(negedge clk); #5;
    check("R8 hold", sts_addr, 32'h2000);
    @(negedge clk); sts_clr = 1'b1; acc_tid = 4'd1; acc_addr = 32'h5000; acc_valid = 1'b1;
    @(negedge clk); sts_clr = 1'b0; acc_valid = 1'b0; #5;
    check("R8 fault with clear recorded", sts_addr, 32'h5000);
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0; #5;
    check("R8 clear drops flag", sts_fault, 1'b0);

    // R9 constant table ignores writes
    access(1, 32'h100, 1);
    check("R9 static permits", s_permit, 1'b1);
    acc_valid = 1'b0;
    cfg_wr(0, 2, flags(1, 0, 0, 0));
    region(1, 32'h800, 32'h8FC, 1, 1, 1, 1);
    access(1, 32'h100, 1);
    check("R9 invalidate ignored", s_permit, 1'b1);
    access(1, 32'h800, 0);
    check("R9 new region ignored", s_fault, 1'b1);
    check("R7 dynamic took new region", permit, 1'b1);
    access(1, 32'h1000, 0);
    check("R7 flags write invalidated entry 0", fault, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule